// File: doc/BRIEF.md
# Two-Level Interrupt Status Bank with Atomic Snapshot

This block gathers interrupt events from a set of transmit queues and from global sources. Queue events land in four secondary status registers, one bit per queue event. Global events land in the upper bits of a primary status register. The low bits of the primary register are summary bits, and each one shows whether its secondary register holds any set bit. One interrupt line is raised from the primary register through a software-written enable mask.

Software can clear the status in two ways. With write-one-to-clear, software writes the bits it has handled back to the register, and only those bits are removed. The second way is a read-and-clear alias of the primary register. A read of it returns the primary value, copies every secondary register into a read-only shadow, and empties all live registers, all on the same clock edge. An event that arrives on that edge is still kept.

Top module: `intStatusBank`

## Requirements
- R1: After reset, every status register, shadow and the mask read as zero, and `irqOut` is low.
- R2: An event pulse on bit k of secondary group i sets bit k of the secondary register at word address 1+i. The bit stays set until it is cleared.
- R3: An event on global source j sets primary bit 4+j. Primary bit i (0..3) reads as one exactly when secondary register i holds any set bit.
- R4: A write to the primary register (address 0) or a secondary register clears exactly the bits written as one. Writing to primary bits 0..3 has no effect on them.
- R5: When an event and a write-one-to-clear hit the same bit in the same cycle, the bit stays set.
- R6: A read of address 5 returns the current primary value. On that edge it copies secondary i into shadow i (address 6+i) and clears the primary and all secondary registers.
- R7: An event that arrives in the read-and-clear cycle stays set in the live register and does not appear in the shadow.
- R8: Writes to shadow addresses have no effect. A shadow keeps its value until the next read of address 5.
- R9: The mask sits at address 10. `irqOut` equals, one cycle later, the OR over the primary bits ANDed with the mask.
- R10: A read of any address other than 5 changes no state. The read data is zero-extended, and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Word address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | DATA_W | Write data |
| busRdEn | input | 1 | Read strobe, data returned in the same cycle |
| busRdData | output | DATA_W | Read data, zero when no read |
| priEvent | input | PRI_W-4 | Global event pulses |
| secEvent | input | 4*SEC_W | Queue event pulses, group i in bits [i*SEC_W +: SEC_W] |
| irqOut | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach is an event that lands on the same edge as the read-and-clear access. The snapshot and the clear then have to split that edge correctly: the shadow must leave the new bit out while the live register keeps it. The bench drives event pulses in the very cycle it issues the alias read. Then it reads the shadows and the live registers separately. A second case is an event arriving together with a write-one-to-clear of the same bit, which the bench sets up by driving both in one cycle. The sweeps go through every bit pattern of each 8-bit group, each paired with a different clear pattern.

// File: rtl/intStatusPkg.sv
package intStatusPkg;
  localparam int NUM_SEC   = 4;
  localparam int SEL_IDX_W = $clog2(NUM_SEC);
  localparam int ADR_PRI   = 0;
  localparam int ADR_SEC0  = 1;
  localparam int ADR_RAC   = ADR_SEC0 + NUM_SEC;
  localparam int ADR_SHD0  = ADR_RAC + 1;
  localparam int ADR_MASK  = ADR_SHD0 + NUM_SEC;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_PRI, SEL_SEC, SEL_RAC, SEL_SHD, SEL_MASK
  } selKind_t;

  typedef struct packed {
    logic                 wrPri;
    logic [NUM_SEC-1:0]   wrSec;
    logic                 wrMask;
    logic                 rac;
    selKind_t             rdKind;
    logic [SEL_IDX_W-1:0] rdIdx;
  } strobes_t;
endpackage

// File: rtl/intStatusCtrl.sv
module intStatusCtrl
  import intStatusPkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output strobes_t          strobes
);
  always_comb begin
    strobes = '0;
    strobes.rdKind = SEL_NONE;
    if (busWrEn) begin
      if (busAddr == ADDR_W'(ADR_PRI)) strobes.wrPri = 1'b1;
      if (busAddr == ADDR_W'(ADR_MASK)) strobes.wrMask = 1'b1;
      for (int i = 0; i < NUM_SEC; i++)
        if (busAddr == ADDR_W'(ADR_SEC0 + i)) strobes.wrSec[i] = 1'b1;
    end
    if (busRdEn) begin
      if (busAddr == ADDR_W'(ADR_PRI)) strobes.rdKind = SEL_PRI;
      if (busAddr == ADDR_W'(ADR_MASK)) strobes.rdKind = SEL_MASK;
      if (busAddr == ADDR_W'(ADR_RAC)) begin
        strobes.rdKind = SEL_RAC;
        strobes.rac    = 1'b1;
      end
      for (int i = 0; i < NUM_SEC; i++) begin
        if (busAddr == ADDR_W'(ADR_SEC0 + i)) begin
          strobes.rdKind = SEL_SEC;
          strobes.rdIdx  = SEL_IDX_W'(i);
        end
        if (busAddr == ADDR_W'(ADR_SHD0 + i)) begin
          strobes.rdKind = SEL_SHD;
          strobes.rdIdx  = SEL_IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/intStatusDatapath.sv
module intStatusDatapath
  import intStatusPkg::*;
#(
  parameter int PRI_W  = 12,
  parameter int SEC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobes_t                       strobes,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [PRI_W-NUM_SEC-1:0]       priEvent,
  input  logic [NUM_SEC*SEC_W-1:0]       secEvent,
  output logic [DATA_W-1:0]              rdData,
  output logic                           irqOut,
  output logic [PRI_W-1:0]               priView,
  output logic [NUM_SEC*SEC_W-1:0]       secLiveFlat,
  output logic [NUM_SEC*SEC_W-1:0]       secShadowFlat,
  output logic [PRI_W-1:0]               maskReg
);
  localparam int DIR_W = PRI_W - NUM_SEC;

  logic [DIR_W-1:0] priDir, priDirNext;
  logic [NUM_SEC-1:0] summary;
  logic [NUM_SEC-1:0][SEC_W-1:0] secLive, secShadow;

  for (genvar g = 0; g < NUM_SEC; g++) begin : gSec
    logic [SEC_W-1:0] secNext;
    always_comb begin
      secNext = secLive[g];
      if (strobes.rac) secNext = '0;
      else if (strobes.wrSec[g]) secNext = secLive[g] & ~wrData[SEC_W-1:0];
      secNext = secNext | secEvent[g*SEC_W +: SEC_W];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        secLive[g]   <= '0;
        secShadow[g] <= '0;
      end else begin
        secLive[g] <= secNext;
        if (strobes.rac) secShadow[g] <= secLive[g];
      end
    end
    assign summary[g] = |secLive[g];
    assign secLiveFlat[g*SEC_W +: SEC_W]   = secLive[g];
    assign secShadowFlat[g*SEC_W +: SEC_W] = secShadow[g];
  end

  always_comb begin
    priDirNext = priDir;
    if (strobes.rac) priDirNext = '0;
    else if (strobes.wrPri) priDirNext = priDir & ~wrData[PRI_W-1:NUM_SEC];
    priDirNext = priDirNext | priEvent;
  end

  assign priView = {priDir, summary};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      priDir  <= '0;
      maskReg <= '0;
      irqOut  <= 1'b0;
    end else begin
      priDir <= priDirNext;
      if (strobes.wrMask) maskReg <= wrData[PRI_W-1:0];
      irqOut <= |(priView & maskReg);
    end
  end

  always_comb begin
    case (strobes.rdKind)
      SEL_PRI, SEL_RAC: rdData = DATA_W'(priView);
      SEL_SEC:          rdData = DATA_W'(secLive[strobes.rdIdx]);
      SEL_SHD:          rdData = DATA_W'(secShadow[strobes.rdIdx]);
      SEL_MASK:         rdData = DATA_W'(maskReg);
      default:          rdData = '0;
    endcase
  end
endmodule

// File: rtl/intStatusBank.sv
module intStatusBank
  import intStatusPkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PRI_W  = 12,
  parameter int SEC_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic                     busWrEn,
  input  logic [DATA_W-1:0]        busWrData,
  input  logic                     busRdEn,
  output logic [DATA_W-1:0]        busRdData,
  input  logic [PRI_W-5:0]         priEvent,
  input  logic [4*SEC_W-1:0]       secEvent,
  output logic                     irqOut
);
  strobes_t strobes;
  logic [PRI_W-1:0] priView, maskReg;
  logic [NUM_SEC*SEC_W-1:0] secLiveFlat, secShadowFlat;

  intStatusCtrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .strobes(strobes)
  );

  intStatusDatapath #(.PRI_W(PRI_W), .SEC_W(SEC_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(busWrData),
    .priEvent(priEvent), .secEvent(secEvent), .rdData(busRdData),
    .irqOut(irqOut), .priView(priView), .secLiveFlat(secLiveFlat),
    .secShadowFlat(secShadowFlat), .maskReg(maskReg)
  );
endmodule

// File: rtl/intStatusChecker.sv
module intStatusChecker
  import intStatusPkg::*;
#(
  parameter int PRI_W = 12,
  parameter int SEC_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input strobes_t                   strobes,
  input logic [PRI_W-NUM_SEC-1:0]   priEvent,
  input logic [NUM_SEC*SEC_W-1:0]   secEvent,
  input logic [PRI_W-1:0]           priView,
  input logic [NUM_SEC*SEC_W-1:0]   secLiveFlat,
  input logic [NUM_SEC*SEC_W-1:0]   secShadowFlat,
  input logic [PRI_W-1:0]           maskReg,
  input logic                       irqOut
);
  assert_evt_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|secEvent) |=> ((secLiveFlat & $past(secEvent)) == $past(secEvent)));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|priEvent) |=> ((priView[PRI_W-1:NUM_SEC] & $past(priEvent)) == $past(priEvent)));

  assert_rac_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rac |=> ((secLiveFlat & ~$past(secEvent)) == '0));

  assert_shadow_copy_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rac |=> (secShadowFlat == $past(secLiveFlat)));

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rac |=> $stable(secShadowFlat));

  assert_irq_timing_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == $past(|(priView & maskReg))));

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.rac && !strobes.wrPri && strobes.wrSec == '0 && secEvent == '0 && priEvent == '0)
      |=> ($stable(secLiveFlat) && $stable(priView)));
endmodule

bind intStatusBank intStatusChecker #(.PRI_W(PRI_W), .SEC_W(SEC_W)) i_chk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .priEvent(priEvent),
  .secEvent(secEvent), .priView(priView), .secLiveFlat(secLiveFlat),
  .secShadowFlat(secShadowFlat), .maskReg(maskReg), .irqOut(irqOut)
);

// File: tb/test_intStatusBank.sv
`timescale 1ns/1ps
module test_intStatusBank;
  localparam int ADDR_W = 4, PRI_W = 12, SEC_W = 8, DATA_W = 32, NS = 4;
  localparam int DIR_W = PRI_W - NS;

  logic clk = 1'b0, rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [DATA_W-1:0] busWrData = '0, busRdData;
  logic [DIR_W-1:0] priEvent = '0;
  logic [NS*SEC_W-1:0] secEvent = '0;
  logic irqOut;

  always #5 clk = ~clk;

  intStatusBank #(.ADDR_W(ADDR_W), .PRI_W(PRI_W), .SEC_W(SEC_W), .DATA_W(DATA_W)) i_intStatusBank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData), .priEvent(priEvent), .secEvent(secEvent),
    .irqOut(irqOut));

  int nChk = 0, nBad = 0;
  logic [DIR_W-1:0] mDir = '0;
  logic [SEC_W-1:0] mSec [NS];
  logic [SEC_W-1:0] mShd [NS];
  logic [PRI_W-1:0] mMask = '0;
  logic mIrq = 1'b0;

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [PRI_W-1:0] modelPri();
    logic [NS-1:0] s;
    for (int i = 0; i < NS; i++) s[i] = |mSec[i];
    return {mDir, s};
  endfunction

  function automatic logic [DATA_W-1:0] modelRead(input logic [ADDR_W-1:0] a);
    int ai = int'(a);
    if (ai == 0 || ai == 5) return DATA_W'(modelPri());
    if (ai >= 1 && ai <= 4) return DATA_W'(mSec[ai-1]);
    if (ai >= 6 && ai <= 9) return DATA_W'(mShd[ai-6]);
    if (ai == 10) return DATA_W'(mMask);
    return '0;
  endfunction

  // Inputs set by caller after a falling edge; one clock; returns after the next falling edge.
  task automatic step(input bit doChk, input string req);
    logic [DATA_W-1:0] got, exp;
    logic irqN;
    #1;
    got = busRdData;
    exp = busRdEn ? modelRead(busAddr) : '0;
    if (doChk) chk(req, got, exp);
    irqN = |(modelPri() & mMask);
    if (busRdEn && busAddr == 4'd5) begin
      for (int i = 0; i < NS; i++) begin mShd[i] = mSec[i]; mSec[i] = '0; end
      mDir = '0;
    end
    if (busWrEn) begin
      if (busAddr == 4'd0) mDir = mDir & ~busWrData[PRI_W-1:NS];
      if (busAddr >= 4'd1 && busAddr <= 4'd4) mSec[busAddr-1] = mSec[busAddr-1] & ~busWrData[SEC_W-1:0];
      if (busAddr == 4'd10) mMask = busWrData[PRI_W-1:0];
    end
    mDir = mDir | priEvent;
    for (int i = 0; i < NS; i++) mSec[i] = mSec[i] | secEvent[i*SEC_W +: SEC_W];
    @(posedge clk);
    @(negedge clk);
    mIrq = irqN;
    chk("R9 irq", DATA_W'(irqOut), DATA_W'(mIrq));
    busWrEn = 1'b0; busRdEn = 1'b0; priEvent = '0; secEvent = '0;
  endtask

  task automatic rd(input int a, input string req);
    busAddr = ADDR_W'(a); busRdEn = 1'b1; step(1'b1, req);
  endtask

  task automatic wr(input int a, input logic [DATA_W-1:0] d);
    busAddr = ADDR_W'(a); busWrEn = 1'b1; busWrData = d; step(1'b0, "");
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChk++; nBad++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NS; i++) begin mSec[i] = '0; mShd[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state of every address
    for (int a = 0; a < 16; a++) if (a != 5) rd(a, "R1 reset");
    chk("R1 irq", DATA_W'(irqOut), '0);

    // R2 / R4 / R10: sweep every pattern of each secondary group
    for (int g = 0; g < NS; g++) begin
      for (int v = 0; v < 256; v++) begin
        secEvent[g*SEC_W +: SEC_W] = SEC_W'(v); step(1'b0, "");
        rd(1 + g, "R2 capture");
        rd(1 + g, "R10 reread");
        rd(0, "R3 summary");
        wr(1 + g, DATA_W'((v * 37 + g * 11) & 255));
        rd(1 + g, "R4 w1c sec");
        wr(1 + g, '1);
      end
    end

    // R3 / R4: global sources, including writes of ones to summary bits
    secEvent[0 +: SEC_W] = 8'h01; step(1'b0, "");
    for (int v = 0; v < 256; v++) begin
      priEvent = DIR_W'(v); step(1'b0, "");
      rd(0, "R3 direct");
      wr(0, DATA_W'(((v * 53) & 255) << NS) | 32'hF);
      rd(0, "R4 summary immune");
      wr(0, '1);
    end
    wr(1, '1);
    rd(0, "R4 all clear");

    // R5: event and clear on the same bit, same cycle
    secEvent[1*SEC_W + 3] = 1'b1; busAddr = 4'd2; busWrEn = 1'b1; busWrData = 32'h08;
    step(1'b0, "");
    rd(2, "R5 set wins sec");
    priEvent = 8'h02; busAddr = 4'd0; busWrEn = 1'b1; busWrData = 32'h20;
    step(1'b0, "");
    rd(0, "R5 set wins pri");

    // R9: mask enables the line
    rd(10, "R9 mask reset");
    wr(10, 32'h020); step(1'b0, "");
    wr(10, 32'h004); step(1'b0, "");

    // R6 / R7: read-and-clear with events landing on the same edge
    secEvent = 32'hA5_3C_81_7E; priEvent = 8'h90; step(1'b0, "");
    secEvent[2*SEC_W] = 1'b1; priEvent = 8'h01;
    rd(5, "R6 rac value");
    for (int i = 0; i < NS; i++) rd(6 + i, "R6 shadow copy");
    for (int i = 0; i < NS; i++) rd(1 + i, "R7 live after rac");
    rd(0, "R7 primary after rac");

    // R8: shadows ignore writes and hold until next alias read
    wr(6, '1); wr(9, '1);
    secEvent = 32'h11_22_33_44; step(1'b0, "");
    for (int i = 0; i < NS; i++) rd(6 + i, "R8 shadow hold");
    rd(5, "R6 second rac");
    for (int i = 0; i < NS; i++) rd(6 + i, "R8 shadow update");
    rd(0, "R6 empty");
    rd(12, "R10 unmapped");
    finishRun();
  end
endmodule